// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block sends host-supplied words to a display panel over an 8080-style parallel bus. The host writes a command/data flag into a four-entry flag queue. It writes the matching bus word into a four-entry word queue of the bus width. When both queues hold at least one entry, the engine takes one entry from each and runs a single bus write cycle. The word goes onto the parallel bus, and the flag sets the register-select line: low means command, high means data. The write strobe pulses low and rises again, and the panel captures the word on that rise. The read strobe stays high throughout.

Each write carries the flag from its own queue entry. Flags and words are paired strictly in push order, and there is no sticky mode. The host watches the full flags before pushing. A push into a full queue is dropped, and the queue contents stay as they were. The low and high strobe phase lengths are parameters counted in system clocks, so the write cycle time can be tuned to the panel's limit (around 40 ns).

The sequencer has four states:

- IDLE: no cycle in progress. It moves to SETUP when both queues are non-empty; this transition pops one entry from each queue and loads the select line and bus.
- SETUP: one clock with the strobe high and the new values already on the pins. It always moves to STROBE_LO.
- STROBE_LO: the strobe is low for `LOW_CYC` clocks, then the state moves to STROBE_HI.
- STROBE_HI: the strobe is high for `HIGH_CYC` clocks, then the state returns to IDLE.

Top module: `lcdw_engine`

## Requirements
- R1: After reset, the write strobe and the read strobe are high, `idle` is high, both empty flags are high, both full flags are low, and the select line and bus are 0.
- R2: A write cycle begins, with `idle` falling, only when both queues are non-empty. A flag with no word, or a word with no flag, leaves the engine in IDLE.
- R3: `cmd_full` is high exactly when the flag queue holds 4 entries. A flag push while it is high is dropped, and the stored entries and their order are unchanged.
- R4: Each write presents, at the strobe's rising edge, the flag (1 = data, 0 = command) and the word from the same position in the two queues, in push order.
- R5: The select line and bus change only in the IDLE-to-SETUP transition. They are therefore stable one clock before the strobe falls, throughout the low phase, and for at least one clock after the rise.
- R6: The write strobe is low for exactly `LOW_CYC` consecutive clocks per cycle. A full cycle lasts 2 + `LOW_CYC` + `HIGH_CYC` clocks when the queues stay non-empty.
- R7: The read strobe is high at all times.
- R8: `idle` is low exactly while a cycle is in SETUP, STROBE_LO or STROBE_HI.
- R9: With no transfer pending, the write strobe rests high, and the select line and bus keep the last driven values.
- R10: The word queue is `BUS_W` bits wide and holds 4 entries. `dat_full` is high exactly when it holds 4 entries, and a word push while it is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push `cmd_flag` into the flag queue |
| cmd_flag | input | 1 | 1 = data write, 0 = command write |
| cmd_full | output | 1 | Flag queue holds 4 entries |
| cmd_empty | output | 1 | Flag queue holds no entries |
| dat_push | input | 1 | Push `dat_word` into the word queue |
| dat_word | input | BUS_W | Word to place on the bus |
| dat_full | output | 1 | Word queue holds 4 entries |
| dat_empty | output | 1 | Word queue holds no entries |
| idle | output | 1 | No bus cycle in progress |
| lcd_dc | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, held high |
| lcd_db | output | BUS_W | Parallel data bus |

## Verification
The engine is tried with four input patterns. Flags pushed alone past the queue depth show that the engine waits for both queues and that the extra flag is dropped rather than overwriting an entry. Words pushed alone show the same wait on the other queue. Back-to-back paired pushes show the minimum cycle spacing and the exact strobe phase lengths. Pseudo-random pushes on the two queues with different rates mix draining, refilling and pushes into a full queue; they separate correct flag-to-word pairing from pairing that is off by one entry.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LO    = 2'd2,
        ST_HI    = 2'd3
    } wr_state_t;
endpackage

// File: rtl/lcdw_queue.sv
module lcdw_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    // R3 / R10: a push into a full queue leaves the write pointer alone
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> $stable(wr_ptr));

    // R10: the occupancy never goes past the depth
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
    import lcdw_pkg::*;
#(
    parameter int W        = 8,
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_avail,
    input  logic         dat_avail,
    input  logic         cmd_head,
    input  logic [W-1:0] dat_head,
    output logic         pop,
    output logic         idle,
    output logic         lcd_dc,
    output logic         lcd_wr_n,
    output logic         lcd_rd_n,
    output logic [W-1:0] lcd_db
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    wr_state_t     state;
    logic [CW-1:0] cnt;
    logic          dc_q;
    logic [W-1:0]  db_q;

    // state register: phase, phase counter and the bus values of the current cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            dc_q  <= 1'b0;
            db_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pop) begin
                    state <= ST_SETUP;
                    dc_q  <= cmd_head;
                    db_q  <= dat_head;
                end
                ST_SETUP: begin
                    state <= ST_LO;
                    cnt   <= '0;
                end
                ST_LO: if (cnt == CW'(LOW_CYC-1)) begin
                    state <= ST_HI;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_HI: if (cnt == CW'(HIGH_CYC-1)) begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        idle     = (state == ST_IDLE);
        pop      = idle && cmd_avail && dat_avail;
        lcd_wr_n = (state != ST_LO);
        lcd_rd_n = 1'b1;
        lcd_dc   = dc_q;
        lcd_db   = db_q;
    end

    // R2: without both entries the engine stays in IDLE
    p_wait_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !(cmd_avail && dat_avail)) |=> idle);

    // R5: select line and bus do not move while the strobe is low (or in the clock before it falls)
    p_setup_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> ($stable(lcd_dc) && $stable(lcd_db)));

    // R5: still held one clock after the rising edge
    p_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_wr_n) |=> ($stable(lcd_dc) && $stable(lcd_db)));

    // R7: the read strobe never goes low
    p_rd_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rd_n);

    // R8 / R9: in IDLE the write strobe rests high
    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> lcd_wr_n);
endmodule

// File: rtl/lcdw_engine.sv
module lcdw_engine #(
    parameter int BUS_W    = 8,
    parameter int DEPTH    = 4,
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_push,
    input  logic             cmd_flag,
    output logic             cmd_full,
    output logic             cmd_empty,
    input  logic             dat_push,
    input  logic [BUS_W-1:0] dat_word,
    output logic             dat_full,
    output logic             dat_empty,
    output logic             idle,
    output logic             lcd_dc,
    output logic             lcd_wr_n,
    output logic             lcd_rd_n,
    output logic [BUS_W-1:0] lcd_db
);
    logic             pop;
    logic             cmd_head;
    logic [BUS_W-1:0] dat_head;

    lcdw_queue #(.W(1), .DEPTH(DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_flag),
        .pop(pop), .dout(cmd_head), .full(cmd_full), .empty(cmd_empty)
    );

    lcdw_queue #(.W(BUS_W), .DEPTH(DEPTH)) u_dat_q (
        .clk(clk), .rst_n(rst_n), .push(dat_push), .din(dat_word),
        .pop(pop), .dout(dat_head), .full(dat_full), .empty(dat_empty)
    );

    lcdw_seq #(.W(BUS_W), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_avail(!cmd_empty), .dat_avail(!dat_empty),
        .cmd_head(cmd_head), .dat_head(dat_head),
        .pop(pop), .idle(idle),
        .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_db(lcd_db)
    );
endmodule

// File: tb/lcdw_engine_tb.sv
module lcdw_engine_tb_top;
    localparam int W = 8;
    localparam int D = 4;
    localparam int L = 2;
    localparam int H = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_push = 1'b0, cmd_flag = 1'b0, dat_push = 1'b0;
    logic [W-1:0] dat_word = '0;
    logic cmd_full, cmd_empty, dat_full, dat_empty, idle;
    logic lcd_dc, lcd_wr_n, lcd_rd_n;
    logic [W-1:0] lcd_db;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcdw_engine #(.BUS_W(W), .DEPTH(D), .LOW_CYC(L), .HIGH_CYC(H)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_push(cmd_push), .cmd_flag(cmd_flag), .cmd_full(cmd_full), .cmd_empty(cmd_empty),
        .dat_push(dat_push), .dat_word(dat_word), .dat_full(dat_full), .dat_empty(dat_empty),
        .idle(idle), .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_db(lcd_db)
    );

    // behavioural reference: queues and a phase counter
    bit           mc[$];
    logic [W-1:0] md[$];
    logic [W:0]   wr_log[$];   // expected {flag,word} per write, in order
    int  ph = 0;               // 0 idle, 1 setup, 2 strobe low, 3 strobe high
    int  pc = 0;
    bit  m_dc = 0;
    logic [W-1:0] m_db = '0;
    int  lo_run = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mc.delete(); md.delete(); wr_log.delete();
            ph = 0; pc = 0; m_dc = 0; m_db = '0;
        end else begin
            bit acc_c, acc_d, pp;
            acc_c = cmd_push && (mc.size() < D);
            acc_d = dat_push && (md.size() < D);
            pp    = (ph == 0) && (mc.size() > 0) && (md.size() > 0);
            case (ph)
                0: if (pp) begin
                    m_dc = mc.pop_front();
                    m_db = md.pop_front();
                    wr_log.push_back({m_dc, m_db});
                    ph = 1;
                end
                1: begin ph = 2; pc = 0; end
                2: if (pc == L-1) begin ph = 3; pc = 0; end else pc++;
                default: if (pc == H-1) begin ph = 0; pc = 0; end else pc++;
            endcase
            if (acc_c) mc.push_back(cmd_flag);
            if (acc_d) md.push_back(dat_word);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison away from the active edge
    logic prev_wr = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(lcd_wr_n == (ph != 2), "R6 wr strobe", lcd_wr_n, (ph != 2));
            chk(lcd_rd_n == 1'b1, "R7 rd strobe", lcd_rd_n, 1);
            chk(idle == (ph == 0), "R8 idle", idle, (ph == 0));
            chk(lcd_dc == m_dc, "R9 dc value", lcd_dc, m_dc);
            chk(lcd_db == m_db, "R5 bus value", lcd_db, m_db);
            chk(cmd_full == (mc.size() == D), "R3 cmd_full", cmd_full, (mc.size() == D));
            chk(cmd_empty == (mc.size() == 0), "R2 cmd_empty", cmd_empty, (mc.size() == 0));
            chk(dat_full == (md.size() == D), "R10 dat_full", dat_full, (md.size() == D));
            chk(dat_empty == (md.size() == 0), "R2 dat_empty", dat_empty, (md.size() == 0));
            if (!lcd_wr_n) lo_run++;
            if (lcd_wr_n && !prev_wr) begin
                chk(lo_run == L, "R6 low length", lo_run, L);
                lo_run = 0;
                if (wr_log.size() > 0) begin
                    logic [W:0] e;
                    e = wr_log.pop_front();
                    chk({lcd_dc, lcd_db} == e, "R4 pair at rise", {lcd_dc, lcd_db}, e);
                end else begin
                    chk(0, "R4 unexpected write", {lcd_dc, lcd_db}, 0);
                end
            end
            prev_wr = lcd_wr_n;
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic push_pair(input bit f, input logic [W-1:0] w);
        cmd_push = 1; cmd_flag = f; dat_push = 1; dat_word = w;
        tick();
        cmd_push = 0; dat_push = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        int rises;
        repeat (3) tick();
        // R1 reset state
        chk(lcd_wr_n && lcd_rd_n && idle, "R1 strobes/idle", {lcd_wr_n, lcd_rd_n, idle}, 3'b111);
        chk(cmd_empty && dat_empty && !cmd_full && !dat_full, "R1 flags",
            {cmd_empty, dat_empty, cmd_full, dat_full}, 4'b1100);
        chk(lcd_dc == 0 && lcd_db == 0, "R1 bus", {lcd_dc, lcd_db}, 0);
        rst_n = 1;
        tick();

        // R2/R3: flags only, five pushes; fifth dropped, no cycle begins
        for (int i = 0; i < 5; i++) begin
            cmd_push = 1; cmd_flag = (i % 2 == 0); tick();
        end
        cmd_push = 0;
        repeat (4) tick();
        chk(cmd_full == 1, "R3 full after 4", cmd_full, 1);
        chk(idle == 1, "R2 no start without word", idle, 1);
        // words: drain the 4 stored flags (1,0,1,0) in order
        for (int i = 0; i < 4; i++) begin
            dat_push = 1; dat_word = W'(8'hA0 + i); tick();
        end
        dat_push = 0;
        repeat (30) tick();
        chk(cmd_empty && dat_empty, "R3 exactly four drained", {cmd_empty, dat_empty}, 2'b11);

        // R2/R10: words only, five pushes; no cycle, fifth dropped
        for (int i = 0; i < 5; i++) begin
            dat_push = 1; dat_word = W'(8'h50 + i); tick();
        end
        dat_push = 0;
        repeat (3) tick();
        chk(dat_full == 1, "R10 full after 4", dat_full, 1);
        chk(idle == 1, "R2 no start without flag", idle, 1);
        for (int i = 0; i < 4; i++) begin
            cmd_push = 1; cmd_flag = 0; tick();
        end
        cmd_push = 0;
        repeat (30) tick();

        // R6: back-to-back pairs, check cycle spacing via the model
        for (int i = 0; i < 4; i++) push_pair(i[0], W'(8'h10 + i));
        rises = 0;
        repeat (40) begin
            logic p;
            p = lcd_wr_n;
            tick();
            if (lcd_wr_n && !p) rises++;
        end
        chk(rises == 4, "R6 four writes", rises, 4);
        // R9: idle keeps last values
        chk(lcd_dc == 1 && lcd_db == 8'h13, "R9 last value kept", {lcd_dc, lcd_db}, {1'b1, 8'h13});

        // pseudo-random mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cmd_push = lfsr[0] & lfsr[3];
            cmd_flag = lfsr[5];
            dat_push = lfsr[1] | lfsr[7];
            dat_word = lfsr[15:8];
            tick();
        end
        cmd_push = 0; dat_push = 0;
        repeat (20) tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        while (!done && cycles < 50000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected done", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule